// File: doc/BRIEF.md
# Counted-Loop Sequencer and Counter-Relative Address Unit

This unit steers instruction fetch and forms data addresses for a processor that has no data-dependent branches. The program counter moves forward by one word on every issued instruction. The only exception is the counted jump. That instruction names one of eight hardware loop counters, a static trip count and a static target. Programs cannot write these loop counters. While the selected counter has iterations left, the jump is taken and the counter counts down. When the counter reaches zero, control falls through, and the counter is re-armed from the instruction's trip count on the next entry.

Data addresses are never taken from register contents. A direct access uses the immediate alone. A counter-relative access adds the immediate to one of eight index counters. Dedicated instructions set an index counter or advance it by a constant. Both the PC and the addresses therefore depend only on instruction fields and counters that the program steps explicitly. The next PC and the memory address come out combinationally in the issue cycle. The PC register updates on the clock edge.

Top module: `loop_addr_ctrl`

## Requirements
- R1: After reset, pc_o is 0, every loop counter is unarmed, every index counter holds 0, and mem_en_o is low while valid_i is low.
- R2: For an issued instruction whose op_i is not 1 (values 0, 2, 3, 4, 5 and the unused codes 6 and 7), next_pc_o equals pc_o + 1 modulo 2^14, and pc_o takes that value at the next edge. With valid_i low, next_pc_o equals pc_o and pc_o holds.
- R3: A counted jump (op_i = 1) whose selected counter has a nonzero remaining count drives next_pc_o to imm_i and decrements that counter. An unarmed counter first takes trip_i as its remaining count.
- R4: A counted jump whose remaining count is zero falls through to pc_o + 1 and leaves its counter unarmed, so the next jump on that counter reloads trip_i. The loop body therefore runs trip_i + 1 times, and a trip_i of 0 falls through at once.
- R5: The eight loop counters, selected by sel_i, are independent, so loops can nest.
- R6: No instruction other than a counted jump on the same counter changes a loop counter. Index initialise and step operations in the middle of a loop leave its iteration sequence unchanged.
- R7: pred_i has no effect on counted jumps, index initialise or index step.
- R8: op_i = 2 loads index counter sel_i with imm_i. op_i = 3 adds imm_i to that counter, modulo 2^14.
- R9: A direct access (op_i = 4) raises mem_en_o and drives mem_addr_o with imm_i.
- R10: A counter-relative access (op_i = 5) raises mem_en_o and drives mem_addr_o with imm_i plus index counter sel_i, modulo 2^14. The counter value used is the one held before the edge.
- R11: mem_en_o is low for every instruction that is not a memory access and whenever valid_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction issues this cycle |
| op_i | input | 3 | Operation code (see requirements) |
| pred_i | input | 1 | Predicate of the instruction; guards write-back only |
| sel_i | input | 3 | Loop or index counter select |
| imm_i | input | 14 | Jump target, address base, or index value/step |
| trip_i | input | 16 | Static trip count of a counted jump |
| pc_o | output | 14 | Current program counter (word address) |
| next_pc_o | output | 14 | PC of the following instruction |
| mem_en_o | output | 1 | A data access is issued this cycle |
| mem_addr_o | output | 14 | Data word address |

## Verification
Straight-line streams with every non-jump op code, and idle cycles between them, show that the PC only steps by one or holds. A single loop run through two full passes distinguishes a correct reload on re-entry from a counter that stays at zero. A zero trip count separates fall-through from an off-by-one take. Nested loops on two counters, with index operations inside a loop body, show that counters do not disturb each other. Index values set with a false predicate, and bases chosen to cross the top of the 14-bit space, expose predicate gating and missing wrap in the relative address sum.

// File: rtl/lac_pkg.sv
package lac_pkg;
  typedef enum logic [2:0] {
    OP_PLAIN    = 3'd0,
    OP_CJMP     = 3'd1,
    OP_IDX_INIT = 3'd2,
    OP_IDX_STEP = 3'd3,
    OP_MEM_DIR  = 3'd4,
    OP_MEM_REL  = 3'd5,
    OP_RSVD6    = 3'd6,
    OP_RSVD7    = 3'd7
  } lac_op_e;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lac_loop_bank.sv
module lac_loop_bank #(
  parameter int unsigned NUM_CTR = 8,
  parameter int unsigned TRIP_W  = 16,
  localparam int unsigned SW     = $clog2(NUM_CTR)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              jump_i,
  input  logic [SW-1:0]     sel_i,
  input  logic [TRIP_W-1:0] trip_i,
  output logic              take_o
);
  logic [NUM_CTR-1:0][TRIP_W-1:0] rem_q;
  logic [NUM_CTR-1:0]             armed_q;
  logic [TRIP_W-1:0]              cur;

  // unarmed counter starts from the static trip count
  assign cur    = armed_q[sel_i] ? rem_q[sel_i] : trip_i;
  assign take_o = jump_i && (cur != '0);

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rem_q[g]   <= '0;
        armed_q[g] <= 1'b0;
      end else if (jump_i && (sel_i == SW'(g))) begin
        if (cur != '0) begin
          rem_q[g]   <= cur - 1'b1;
          armed_q[g] <= 1'b1;
        end else begin
          armed_q[g] <= 1'b0;
        end
      end
    end
  end

  a_r6_counters_private: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !jump_i |=> ($stable(rem_q) && $stable(armed_q)));

  a_r4_zero_falls_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_i && armed_q[sel_i] && rem_q[sel_i] == '0) |-> !take_o);

  a_r4_zero_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_i && !take_o) |=> !armed_q[$past(sel_i)]);

  a_r3_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_i && armed_q[sel_i] && take_o) |=>
      (rem_q[$past(sel_i)] == $past(rem_q[sel_i]) - 1'b1));

  a_r5_other_ctr_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_i |=> (rem_q[$past(sel_i) + 1'b1] == $past(rem_q[sel_i + 1'b1])));
endmodule

// File: rtl/lac_index_bank.sv
module lac_index_bank #(
  parameter int unsigned NUM_CTR = 8,
  parameter int unsigned AW      = 14,
  localparam int unsigned SW     = $clog2(NUM_CTR)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          step_i,
  input  logic [SW-1:0] sel_i,
  input  logic [AW-1:0] val_i,
  output logic [AW-1:0] idx_o
);
  logic [NUM_CTR-1:0][AW-1:0] idx_q;

  assign idx_o = idx_q[sel_i];

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_idx
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        idx_q[g] <= '0;
      end else if (sel_i == SW'(g)) begin
        if (init_i)      idx_q[g] <= val_i;
        else if (step_i) idx_q[g] <= idx_q[g] + val_i;
      end
    end
  end

  a_r8_init_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (idx_q[$past(sel_i)] == $past(val_i)));

  a_r8_step_adds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !init_i) |=> (idx_q[$past(sel_i)] == $past(idx_o) + $past(val_i)));

  a_r8_idle_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !step_i) |=> $stable(idx_q));
endmodule

// File: rtl/lac_pc_unit.sv
module lac_pc_unit #(
  parameter int unsigned PW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          take_i,
  input  logic [PW-1:0] target_i,
  output logic [PW-1:0] pc_o,
  output logic [PW-1:0] next_pc_o
);
  logic [PW-1:0] pc_q;

  always_comb begin
    if (!valid_i)    next_pc_o = pc_q;
    else if (take_i) next_pc_o = target_i;
    else             next_pc_o = pc_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= next_pc_o;
  end

  assign pc_o = pc_q;

  a_r2_pc_follows_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pc_o == $past(next_pc_o)));

  a_r2_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(pc_o));
endmodule

// File: rtl/loop_addr_ctrl.sv
module loop_addr_ctrl #(
  parameter int unsigned NUM_CTR    = 8,
  parameter int unsigned IMEM_BYTES = 65536,
  parameter int unsigned DMEM_BYTES = 65536,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned TRIP_W     = 16,
  localparam int unsigned SW = $clog2(NUM_CTR),
  localparam int unsigned PW = $clog2(IMEM_BYTES / WORD_BYTES),
  localparam int unsigned AW = $clog2(DMEM_BYTES / WORD_BYTES),
  localparam int unsigned IW = lac_pkg::max_u(PW, AW)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic              pred_i,
  input  logic [SW-1:0]     sel_i,
  input  logic [IW-1:0]     imm_i,
  input  logic [TRIP_W-1:0] trip_i,
  output logic [PW-1:0]     pc_o,
  output logic [PW-1:0]     next_pc_o,
  output logic              mem_en_o,
  output logic [AW-1:0]     mem_addr_o
);
  import lac_pkg::*;

  lac_op_e       op;
  logic          is_jump, is_init, is_step, is_dir, is_rel, take;
  logic [AW-1:0] idx_rd;

  assign op      = lac_op_e'(op_i);
  // jump and index ops commit without regard to pred_i
  assign is_jump = valid_i && (op == OP_CJMP);
  assign is_init = valid_i && (op == OP_IDX_INIT);
  assign is_step = valid_i && (op == OP_IDX_STEP);
  assign is_dir  = valid_i && (op == OP_MEM_DIR);
  assign is_rel  = valid_i && (op == OP_MEM_REL);

  lac_loop_bank #(.NUM_CTR(NUM_CTR), .TRIP_W(TRIP_W)) i_loop_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .jump_i (is_jump),
    .sel_i  (sel_i),
    .trip_i (trip_i),
    .take_o (take)
  );

  lac_index_bank #(.NUM_CTR(NUM_CTR), .AW(AW)) i_index_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (is_init),
    .step_i (is_step),
    .sel_i  (sel_i),
    .val_i  (imm_i[AW-1:0]),
    .idx_o  (idx_rd)
  );

  lac_pc_unit #(.PW(PW)) i_pc_unit (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .take_i    (take),
    .target_i  (imm_i[PW-1:0]),
    .pc_o      (pc_o),
    .next_pc_o (next_pc_o)
  );

  assign mem_en_o   = is_dir || is_rel;
  assign mem_addr_o = is_rel ? (imm_i[AW-1:0] + idx_rd) : imm_i[AW-1:0];

  a_r2_straight_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i != 3'd1) |-> (next_pc_o == pc_o + 1'b1));

  a_r3_jump_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd1 && next_pc_o != pc_o + 1'b1) |-> (next_pc_o == imm_i[PW-1:0]));

  a_r9_direct_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd4) |-> (mem_en_o && mem_addr_o == imm_i[AW-1:0]));

  a_r11_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && (op_i == 3'd4 || op_i == 3'd5)) |-> !mem_en_o);

  a_r7_init_ignores_pred: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd5 && imm_i == '0 && $past(sel_i) == sel_i &&
     $past(valid_i && op_i == 3'd2 && !pred_i)) |-> (mem_addr_o == $past(imm_i[AW-1:0])));
endmodule

// File: tb/test_loop_addr_ctrl.sv
module test_loop_addr_ctrl;
  localparam int PW = 14;
  localparam int AW = 14;
  localparam int IW = 14;

  typedef struct {
    logic [PW-1:0] pc;
    logic [PW-1:0] npc;
    logic          en;
    logic [AW-1:0] addr;
    string         tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, pred = 1'b0;
  logic [2:0] op = '0, sel = '0;
  logic [IW-1:0] imm = '0;
  logic [15:0] trip = '0;
  logic [PW-1:0] pc, npc;
  logic mem_en;
  logic [AW-1:0] mem_addr;

  int errors = 0, checks = 0;
  bit done = 0;
  exp_t sb[$];

  // reference state from the requirements
  logic [PW-1:0] m_pc = '0;
  logic [15:0]   m_rem [8];
  bit            m_arm [8];
  logic [AW-1:0] m_idx [8];

  always #5 clk = ~clk;

  loop_addr_ctrl i_loop_addr_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .pred_i(pred),
    .sel_i(sel), .imm_i(imm), .trip_i(trip), .pc_o(pc), .next_pc_o(npc),
    .mem_en_o(mem_en), .mem_addr_o(mem_addr)
  );

  task automatic issue(input bit v, input logic [2:0] o, input logic [2:0] s,
                       input logic [IW-1:0] im, input logic [15:0] tr,
                       input bit p, input string tag);
    exp_t e;
    logic [15:0] cur;
    @(posedge clk); #2;
    valid = v; op = o; sel = s; imm = im; trip = tr; pred = p;
    e.pc = m_pc; e.tag = tag; e.en = 1'b0; e.addr = '0;
    e.npc = v ? m_pc + 1'b1 : m_pc;
    if (v && o == 3'd1) begin
      cur = m_arm[s] ? m_rem[s] : tr;
      if (cur != 0) begin
        e.npc = im; m_rem[s] = cur - 1'b1; m_arm[s] = 1;
      end else m_arm[s] = 0;
    end
    if (v && o == 3'd4) begin e.en = 1'b1; e.addr = im; end
    if (v && o == 3'd5) begin e.en = 1'b1; e.addr = im + m_idx[s]; end
    if (v && o == 3'd2) m_idx[s] = im;
    if (v && o == 3'd3) m_idx[s] = m_idx[s] + im;
    m_pc = e.npc;
    sb.push_back(e);
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (pc !== e.pc || npc !== e.npc || mem_en !== e.en || (e.en && mem_addr !== e.addr)) begin
        errors++;
        $display("FAIL %s: pc=%h npc=%h en=%b addr=%h expected pc=%h npc=%h en=%b addr=%h",
                 e.tag, pc, npc, mem_en, mem_addr, e.pc, e.npc, e.en, e.addr);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_rem[i] = '0; m_arm[i] = 0; m_idx[i] = '0; end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state, index counters read as zero
    issue(0, 3'd0, 0, 0, 0, 0, "R1 reset pc");
    for (int k = 0; k < 8; k++) issue(1, 3'd5, 3'(k), 14'h0, 0, 0, "R1 idx zero");
    issue(1, 3'd1, 7, 14'h0123, 0, 0, "R1 unarmed zero trip");
    // R2 straight line, idle, reserved codes
    issue(1, 3'd0, 0, 14'h3FFF, 5, 1, "R2 plain");
    issue(0, 3'd0, 0, 0, 0, 0, "R2 idle hold");
    issue(1, 3'd6, 2, 0, 0, 0, "R2 code 6");
    issue(1, 3'd7, 2, 0, 0, 0, "R2 code 7");
    // R3 R4 loop with trip 2, run twice
    for (int pass = 0; pass < 2; pass++)
      for (int it = 0; it < 3; it++) begin
        issue(1, 3'd0, 0, 0, 0, 0, "R2 body");
        issue(1, 3'd1, 0, 14'h0010, 2, 0, it < 2 ? "R3 taken" : "R4 fall and reload");
      end
    // R7 predicate false on counted jump
    issue(1, 3'd1, 4, 14'h0200, 1, 0, "R7 jump pred low");
    issue(1, 3'd1, 4, 14'h0200, 1, 1, "R4 jump trip1 falls");
    // R5 nested loops on counters 1 and 2
    for (int o = 0; o < 2; o++) begin
      for (int in = 0; in < 4; in++)
        issue(1, 3'd1, 2, 14'h0040, 3, 0, "R5 inner");
      issue(1, 3'd1, 1, 14'h0030, 1, 0, "R5 outer");
    end
    // R6 index ops inside loop on counter 3
    issue(1, 3'd1, 3, 14'h0050, 2, 0, "R6 first pass");
    issue(1, 3'd2, 3, 14'h1234, 0, 1, "R6 idx init");
    issue(1, 3'd3, 3, 14'h0001, 0, 1, "R6 idx step");
    issue(1, 3'd1, 3, 14'h0050, 2, 0, "R6 second pass");
    issue(1, 3'd1, 3, 14'h0050, 2, 0, "R6 falls");
    // R7 R8 index init with predicate low, then step and wrap
    issue(1, 3'd2, 5, 14'h3FFF, 0, 0, "R7 idx init pred low");
    issue(1, 3'd5, 5, 14'h0000, 0, 0, "R8 init value");
    issue(1, 3'd3, 5, 14'h0002, 0, 0, "R7 idx step pred low");
    issue(1, 3'd5, 5, 14'h0000, 0, 0, "R8 step wraps");
    issue(1, 3'd5, 5, 14'h3FFE, 0, 0, "R10 rel sum");
    issue(1, 3'd3, 5, 14'h0004, 0, 1, "R8 step");
    issue(1, 3'd5, 5, 14'h3FFF, 0, 1, "R10 rel wraps");
    issue(1, 3'd5, 3, 14'h0100, 0, 0, "R10 rel other ctr");
    // R9 direct, R11 no access
    issue(1, 3'd4, 5, 14'h3ABC, 0, 0, "R9 direct");
    issue(1, 3'd4, 0, 14'h0007, 0, 1, "R9 direct 2");
    issue(1, 3'd0, 0, 14'h0007, 0, 1, "R11 plain no access");
    issue(1, 3'd1, 6, 14'h0007, 0, 1, "R11 jump no access");
    issue(0, 3'd4, 0, 14'h0007, 0, 1, "R11 invalid no access");
    issue(0, 3'd0, 0, 0, 0, 0, "R2 final idle");
    @(posedge clk); @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule